// File: doc/BRIEF.md
# SDRAM Per-Bank Open-Row Page Manager

This block keeps one open row per internal bank of a single chip-select region of an SDRAM and turns each read or write request into the shortest command sequence that reaches the data. When the addressed bank already holds the requested row, the column command goes out at once. When the bank is idle, an activate opens the row first. When the bank holds some other row, only that bank is precharged, then reopened with the new row. Rows in the other banks remain open, so later accesses to them still go straight to the column command.

A refresh request is latched and serviced at the next request boundary. The block issues a precharge-all, waits the precharge gap, issues the refresh command, waits the refresh gap, and marks every bank as closed. Fixed NOP gaps, set by parameters, separate dependent commands. The request handshake stays not-ready while a sequence or a refresh is running. Data transfer, chip-select decoding and any timing other than these gaps are handled elsewhere.

Top module: `sdram_page_mgr`

## Requirements
- R1: After reset `cmd_o` is NOP (0), `req_ready_o` is high and every bank is closed, so the first access to any bank produces ACT and never PRE.
- R2: A request to an open bank whose open row equals the requested row produces, in the cycle after acceptance, READ (3) or WRITE (4, when `req_we_i` is 1) on that bank, with the column zero-extended on `cmd_addr_o`, and no PRE or ACT.
- R3: A request to a closed bank produces ACT (2) with the row on `cmd_addr_o`, then exactly `T_RCD` NOP cycles, then the column command. No PRE is issued.
- R4: A request to an open bank holding a different row produces PRE (1) to that bank only, then `T_RP` NOPs, ACT with the new row, `T_RCD` NOPs, and the column command.
- R5: Each bank keeps its own open row. A row miss or activate in one bank leaves the rows open in the other banks unchanged.
- R6: A refresh produces PALL (5), exactly `T_RP` NOPs, REF (6), then `T_RFC` NOPs. After it every bank is closed.
- R7: A pulse on `ref_req_i` does not interrupt a sequence that has already started; the refresh follows its column command. A pending refresh is served before a request that is waiting.
- R8: `req_ready_o` is low from the cycle after a miss is accepted until the cycle its column command appears, so a miss holds the next request for `T_RP+T_RCD+2` cycles. After a hit the next request can be accepted in the following cycle.
- R9: Bank and address are 0 on PRE-ALL, REF and NOP, and PRE carries address 0 with the target bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_bank_i | input | BANK_W | Target internal bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_we_i | input | 1 | 1 = write, 0 = read |
| ref_req_i | input | 1 | Refresh request pulse, latched internally |
| cmd_o | output | 3 | Command: 0 NOP, 1 PRE, 2 ACT, 3 READ, 4 WRITE, 5 PALL, 6 REF |
| cmd_bank_o | output | BANK_W | Bank for the command |
| cmd_addr_o | output | ADDR_W | Row on ACT, column on READ/WRITE, 0 otherwise |

## Verification
The assertions assume that the request fields stay stable while `req_valid_i` is high and not yet accepted, that the bank index is below `BANKS`, and that `ref_req_i` is a single-cycle pulse. The driver task changes inputs only on the falling edge. It holds valid and the fields until it sees ready, and it pulses refresh for exactly one cycle. The checker builds its own model of which banks are open from the command stream. It requires that PRE goes only to an open bank, ACT only to a closed bank, and column commands only to open banks, and that the gaps before dependent commands are respected.

// File: rtl/sdram_page_pkg.sv
package sdram_page_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PRE  = 3'd1,
    CMD_ACT  = 3'd2,
    CMD_RD   = 3'd3,
    CMD_WR   = 3'd4,
    CMD_PALL = 3'd5,
    CMD_REF  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RP,
    ST_RCD,
    ST_PALL,
    ST_RFC
  } seq_st_e;
endpackage

// File: rtl/page_row_table.sv
module page_row_table #(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_en_i,
  input  logic [BANK_W-1:0] open_bank_i,
  input  logic [ROW_W-1:0]  open_row_i,
  input  logic              close_all_i,
  input  logic [BANK_W-1:0] look_bank_i,
  output logic              look_open_o,
  output logic [ROW_W-1:0]  look_row_o
);
  logic [BANKS-1:0] vld_w;
  logic [ROW_W-1:0] row_w [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             v_q;
    logic [ROW_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        r_q <= '0;
      end else if (close_all_i) begin
        v_q <= 1'b0;
      end else if (open_en_i && open_bank_i == BANK_W'(b)) begin
        v_q <= 1'b1;
        r_q <= open_row_i;
      end
    end
    assign vld_w[b] = v_q;
    assign row_w[b] = r_q;
  end

  assign look_open_o = vld_w[look_bank_i];
  assign look_row_o  = row_w[look_bank_i];
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/page_cmd_seq.sv
module page_cmd_seq
  import sdram_page_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 3,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2,
  parameter int T_RFC  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_we_i,
  input  logic              ref_req_i,
  input  logic              look_open_i,
  input  logic [ROW_W-1:0]  look_row_i,
  input  logic              gap_zero_i,
  output logic              gap_load_o,
  output logic [CNT_W-1:0]  gap_val_o,
  output logic              tbl_open_en_o,
  output logic [BANK_W-1:0] tbl_open_bank_o,
  output logic [ROW_W-1:0]  tbl_open_row_o,
  output logic              tbl_close_all_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  seq_st_e           st_q, st_d;
  cmd_e              cmd_q, cmd_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ref_pend_q, ref_clr;
  logic [BANK_W-1:0] l_bank_q, l_bank_d;
  logic [ROW_W-1:0]  l_row_q, l_row_d;
  logic [COL_W-1:0]  l_col_q, l_col_d;
  logic              l_we_q, l_we_d;

  assign req_ready_o = (st_q == ST_IDLE) && !ref_pend_q;

  always_comb begin
    st_d            = st_q;
    cmd_d           = CMD_NOP;
    bank_d          = '0;
    addr_d          = '0;
    gap_load_o      = 1'b0;
    gap_val_o       = '0;
    tbl_open_en_o   = 1'b0;
    tbl_open_bank_o = l_bank_q;
    tbl_open_row_o  = l_row_q;
    tbl_close_all_o = 1'b0;
    ref_clr         = 1'b0;
    l_bank_d        = l_bank_q;
    l_row_d         = l_row_q;
    l_col_d         = l_col_q;
    l_we_d          = l_we_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend_q) begin
          cmd_d           = CMD_PALL;
          tbl_close_all_o = 1'b1;
          ref_clr         = 1'b1;
          gap_load_o      = 1'b1;
          gap_val_o       = CNT_W'(T_RP);
          st_d            = ST_PALL;
        end else if (req_valid_i) begin
          l_bank_d = req_bank_i;
          l_row_d  = req_row_i;
          l_col_d  = req_col_i;
          l_we_d   = req_we_i;
          bank_d   = req_bank_i;
          if (look_open_i && look_row_i == req_row_i) begin
            cmd_d  = req_we_i ? CMD_WR : CMD_RD;
            addr_d = ADDR_W'(req_col_i);
          end else if (look_open_i) begin
            cmd_d      = CMD_PRE;
            gap_load_o = 1'b1;
            gap_val_o  = CNT_W'(T_RP);
            st_d       = ST_RP;
          end else begin
            cmd_d           = CMD_ACT;
            addr_d          = ADDR_W'(req_row_i);
            tbl_open_en_o   = 1'b1;
            tbl_open_bank_o = req_bank_i;
            tbl_open_row_o  = req_row_i;
            gap_load_o      = 1'b1;
            gap_val_o       = CNT_W'(T_RCD);
            st_d            = ST_RCD;
          end
        end
      end
      ST_RP: if (gap_zero_i) begin
        cmd_d         = CMD_ACT;
        bank_d        = l_bank_q;
        addr_d        = ADDR_W'(l_row_q);
        tbl_open_en_o = 1'b1;
        gap_load_o    = 1'b1;
        gap_val_o     = CNT_W'(T_RCD);
        st_d          = ST_RCD;
      end
      ST_RCD: if (gap_zero_i) begin
        cmd_d  = l_we_q ? CMD_WR : CMD_RD;
        bank_d = l_bank_q;
        addr_d = ADDR_W'(l_col_q);
        st_d   = ST_IDLE;
      end
      ST_PALL: if (gap_zero_i) begin
        cmd_d      = CMD_REF;
        gap_load_o = 1'b1;
        gap_val_o  = CNT_W'(T_RFC);
        st_d       = ST_RFC;
      end
      ST_RFC: if (gap_zero_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cmd_q      <= CMD_NOP;
      bank_q     <= '0;
      addr_q     <= '0;
      ref_pend_q <= 1'b0;
      l_bank_q   <= '0;
      l_row_q    <= '0;
      l_col_q    <= '0;
      l_we_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      cmd_q      <= cmd_d;
      bank_q     <= bank_d;
      addr_q     <= addr_d;
      ref_pend_q <= (ref_pend_q && !ref_clr) || ref_req_i;
      l_bank_q   <= l_bank_d;
      l_row_q    <= l_row_d;
      l_col_q    <= l_col_d;
      l_we_q     <= l_we_d;
    end
  end

  assign cmd_o      = cmd_q;
  assign cmd_bank_o = bank_q;
  assign cmd_addr_o = addr_q;
endmodule

// File: rtl/sdram_page_mgr.sv
module sdram_page_mgr #(
  parameter int BANKS = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_RFC = 6,
  localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int GAP_MAX = (T_RFC > T_RP) ? ((T_RFC > T_RCD) ? T_RFC : T_RCD)
                                          : ((T_RP > T_RCD) ? T_RP : T_RCD),
  localparam int CNT_W   = $clog2(GAP_MAX + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_we_i,
  input  logic              ref_req_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  logic              look_open, gap_zero, gap_load, open_en, close_all;
  logic [ROW_W-1:0]  look_row, open_row;
  logic [BANK_W-1:0] open_bank;
  logic [CNT_W-1:0]  gap_val;

  page_row_table #(.BANKS(BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_tbl (
    .clk_i, .rst_ni,
    .open_en_i(open_en), .open_bank_i(open_bank), .open_row_i(open_row),
    .close_all_i(close_all), .look_bank_i(req_bank_i),
    .look_open_o(look_open), .look_row_o(look_row)
  );

  gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk_i, .rst_ni, .load_i(gap_load), .load_val_i(gap_val), .zero_o(gap_zero)
  );

  page_cmd_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC)
  ) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_bank_i, .req_row_i, .req_col_i, .req_we_i,
    .ref_req_i,
    .look_open_i(look_open), .look_row_i(look_row), .gap_zero_i(gap_zero),
    .gap_load_o(gap_load), .gap_val_o(gap_val),
    .tbl_open_en_o(open_en), .tbl_open_bank_o(open_bank), .tbl_open_row_o(open_row),
    .tbl_close_all_o(close_all),
    .cmd_o, .cmd_bank_o, .cmd_addr_o
  );
endmodule

// File: rtl/sdram_page_mgr_chk.sv
module sdram_page_mgr_chk
  import sdram_page_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank_o
);
  logic [BANKS-1:0] open_q;
  logic [2:0]       last_q;
  logic [7:0]       nops_q;
  logic             is_col;

  assign is_col = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
      last_q <= CMD_NOP;
      nops_q <= 8'hff;
    end else begin
      if (cmd_o == CMD_PALL)     open_q <= '0;
      else if (cmd_o == CMD_PRE) open_q[cmd_bank_o] <= 1'b0;
      else if (cmd_o == CMD_ACT) open_q[cmd_bank_o] <= 1'b1;
      if (cmd_o != CMD_NOP) begin
        last_q <= cmd_o;
        nops_q <= '0;
      end else if (nops_q != 8'hff) begin
        nops_q <= nops_q + 1'b1;
      end
    end
  end

  assert_col_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> open_q[cmd_bank_o]);
  assert_act_closed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> !open_q[cmd_bank_o]);
  assert_rcd_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_col && last_q == CMD_ACT) |-> (int'(nops_q) >= T_RCD));
  assert_pre_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |-> open_q[cmd_bank_o]);
  assert_rp_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT && last_q == CMD_PRE) |-> (int'(nops_q) >= T_RP));
  assert_ref_after_pall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> (last_q == CMD_PALL && int'(nops_q) >= T_RP));
  assert_accept_issues_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (cmd_o inside {CMD_RD, CMD_WR, CMD_PRE, CMD_ACT}));
endmodule

bind sdram_page_mgr sdram_page_mgr_chk #(
  .BANKS(BANKS), .BANK_W(BANK_W), .T_RP(T_RP), .T_RCD(T_RCD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o)
);

// File: tb/sim_sdram_page_mgr.sv
`timescale 1ns/1ps
module sim_sdram_page_mgr;
  localparam int BANKS = 4, ROW_W = 13, COL_W = 10;
  localparam int T_RP = 2, T_RCD = 2, T_RFC = 6;
  localparam int BANK_W = 2, ADDR_W = 13;

  typedef struct {
    int    cmd;
    int    bank;
    int    addr;
    int    gap;
    string tag;
  } exp_t;

  logic              clk = 1'b0, rst_ni = 1'b0;
  logic              req_valid_i = 1'b0, req_we_i = 1'b0, ref_req_i = 1'b0;
  logic              req_ready_o;
  logic [BANK_W-1:0] req_bank_i = '0;
  logic [ROW_W-1:0]  req_row_i = '0;
  logic [COL_W-1:0]  req_col_i = '0;
  logic [2:0]        cmd_o;
  logic [BANK_W-1:0] cmd_bank_o;
  logic [ADDR_W-1:0] cmd_addr_o;

  int checks = 0, failures = 0, cycles = 0, nops = 1000;
  bit done = 0;
  exp_t q[$];
  bit   m_open [BANKS];
  int   m_row  [BANKS];

  always #10 clk = ~clk;

  sdram_page_mgr #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
                   .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC)) u0 (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_bank_i, .req_row_i,
    .req_col_i, .req_we_i, .ref_req_i, .cmd_o, .cmd_bank_o, .cmd_addr_o);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int c, input int b, input int a, input int g, input string t);
    exp_t e;
    e.cmd = c; e.bank = b; e.addr = a; e.gap = g; e.tag = t;
    q.push_back(e);
  endtask

  // expected sequence from the bench's own open-row model
  task automatic send(input int b, input int r, input int c, input bit we,
                      input string t, output int waits);
    int col_cmd;
    col_cmd = we ? 4 : 3;
    if (m_open[b] && m_row[b] == r) begin
      push(col_cmd, b, c, -1, t);
    end else begin
      if (m_open[b]) begin
        push(1, b, 0, -1, t);
        push(2, b, r, T_RP, t);
      end else begin
        push(2, b, r, -1, t);
      end
      push(col_cmd, b, c, T_RCD, t);
      m_open[b] = 1; m_row[b] = r;
    end
    req_valid_i = 1'b1; req_bank_i = BANK_W'(b); req_row_i = ROW_W'(r);
    req_col_i = COL_W'(c); req_we_i = we;
    waits = 0;
    while (!req_ready_o) begin
      @(negedge clk);
      waits++;
    end
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic do_ref(input string t);
    push(5, 0, 0, -1, t);
    push(6, 0, 0, T_RP, t);
    for (int i = 0; i < BANKS; i++) m_open[i] = 0;
    ref_req_i = 1'b1;
    @(negedge clk);
    ref_req_i = 1'b0;
  endtask

  // monitor: compares every non-NOP command against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && !done) begin
        if (cmd_o != 3'd0) begin
          if (q.size() == 0) begin
            check(1'b0, "unexpected command R2", int'(cmd_o), 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(int'(cmd_o) == e.cmd, {e.tag, " cmd"}, int'(cmd_o), e.cmd);
            check(int'(cmd_bank_o) == e.bank, {e.tag, " bank"}, int'(cmd_bank_o), e.bank);
            check(int'(cmd_addr_o) == e.addr, {e.tag, " addr"}, int'(cmd_addr_o), e.addr);
            if (e.gap >= 0) check(nops == e.gap, {e.tag, " nop gap"}, nops, e.gap);
          end
          nops = 0;
        end else begin
          nops++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        done = 1;
        failures++;
        $display("FAIL watchdog expired R1 actual=%0d expected=%0d", cycles, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int w;
    for (int i = 0; i < BANKS; i++) begin m_open[i] = 0; m_row[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(cmd_o == 3'd0, "R1 reset cmd NOP", int'(cmd_o), 0);
    check(req_ready_o == 1'b1, "R1 reset ready", int'(req_ready_o), 1);

    send(0, 5, 3, 0, "R1 R3 first access activates", w);
    send(0, 5, 7, 1, "R2 row hit write", w);
    send(1, 9, 1, 0, "R3 idle bank", w);
    send(0, 6, 2, 0, "R4 row miss", w);
    send(1, 9, 4, 1, "R5 other bank kept open", w);
    send(2, 8191, 1023, 0, "R5 bank2 open", w);
    send(3, 0, 0, 1, "R5 bank3 open", w);
    send(0, 6, 11, 0, "R5 hit bank0", w);
    send(1, 9, 12, 0, "R5 hit bank1", w);
    send(2, 8191, 13, 1, "R5 hit bank2", w);
    send(3, 0, 14, 0, "R5 hit bank3", w);
    check(w == 0, "R8 hit back-to-back", w, 0);

    do_ref("R6 refresh");
    send(0, 6, 5, 0, "R6 bank closed after refresh", w);
    send(3, 0, 1, 0, "R6 R9 bank3 closed after refresh", w);

    send(0, 7, 1, 0, "R8 miss", w);
    send(0, 7, 9, 0, "R8 hit after miss", w);
    check(w == T_RP + T_RCD + 2, "R8 ready low during miss", w, T_RP + T_RCD + 2);

    send(3, 4, 2, 1, "R7 sequence not interrupted", w);
    do_ref("R7 refresh after sequence");
    send(2, 3, 6, 0, "R7 request after deferred refresh", w);
    check(w > 0, "R7 request held while refresh pending", w, 1);

    do_ref("R7 refresh priority");
    send(2, 3, 8, 1, "R7 waiting request after refresh", w);
    check(w >= T_RP + T_RFC + 2, "R7 refresh first", w, T_RP + T_RFC + 2);

    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2 all expected commands seen", q.size(), 0);
    check(req_ready_o == 1'b1, "R8 ready after drain", int'(req_ready_o), 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule